// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block sits beside a floating-point arithmetic unit and turns the unit's raw exception flags into architectural state and trap decisions. For each completed instruction the datapath presents the flags it raised, together with a per-instruction ignore mask, the software enable mask, the destination register index and a software-completion mode bit. The controller folds the flags into a sticky status register and decides whether a trap is taken. When one is taken, it emits a one-cycle trap strobe with a summary word and a register write mask for the handler.

The two trap policies differ in when the ignore mask is applied. Without software completion, every raised flag is recorded first, and only the trap decision is filtered. With software completion, ignored flags are never recorded, and the reported flags are further restricted to the enabled ones. A second request type screens a 64-bit double-precision operand before an instruction uses it. Denormals, infinities and NaNs are trapped according to the mode, with a gentler rule for compare instructions and a flush-to-zero override in the software-completion mode.

All decisions are registered. Results appear one clock after the request, and the sticky register can be overwritten through an explicit write port.

Top module: `fp_trap_ctrl`

## Requirements
- R1: After reset the sticky register is zero and the trap strobe, summary and write mask are zero.
- R2: Flag bits are [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact, [5] integer overflow, in the flag inputs, the masks, the sticky register and summary bits [5:0]. Without software completion, a flag request ORs all raised flags into the sticky register. It traps when flags AND NOT ignore is nonzero, and the summary is flags AND NOT ignore with bit 6 clear. The enable mask has no effect in this mode.
- R3: With software completion, only flags AND NOT ignore are ORed into the sticky register. A trap fires when that set is nonzero, and the summary is that set AND enable, with summary bit 6 (software completion) set.
- R4: A trap from a flag request drives a 64-bit write mask with exactly one bit set, at the destination index. When no trap fires, the strobe, summary and mask are all zero.
- R5: Results are registered: the strobe, summary and mask appear in the cycle after the request and last exactly one cycle.
- R6: With no request, or a flag request carrying no flags, the sticky register is unchanged and no trap fires.
- R7: An arithmetic operand check without software completion behaves as follows. Exponent (bits 62:52) zero with a nonzero fraction (bits 51:0) traps with summary invalid and leaves the sticky register unchanged. An all-ones exponent sets sticky invalid and traps with summary invalid.
- R8: A compare operand check without software completion lets infinities pass. A NaN sets sticky invalid and traps with summary invalid, and denormals trap as in R7.
- R9: An operand check with software completion traps only on a nonzero denormal of either sign, with summary invalid plus bit 6. The trap is suppressed when flush-to-zero is set. Infinities, NaNs and zeros pass.
- R10: Traps from operand checks carry an all-zero write mask.
- R11: An operand check takes priority over a flag request in the same cycle. A sticky write replaces the register and overrides any accumulation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_req | input | 1 | Flag report request |
| flags | input | 6 | Raw exception flags from the datapath |
| ign_mask | input | 6 | Per-instruction ignore mask |
| en_mask | input | 6 | Software trap enable mask |
| dst_idx | input | 6 | Destination register index |
| swc_mode | input | 1 | Software-completion policy select |
| chk_req | input | 1 | Operand screening request |
| chk_cmp | input | 1 | Operand check is for a compare |
| opnd | input | 64 | Double-precision operand to screen |
| ftz | input | 1 | Flush-inputs-to-zero control |
| sticky_we | input | 1 | Explicit sticky register write |
| sticky_wdata | input | 6 | Value for the sticky register write |
| sticky_q | output | 6 | Sticky exception status |
| trap | output | 1 | One-cycle trap strobe |
| trap_sum | output | 7 | Trap summary: flags [5:0], software completion [6] |
| trap_wmask | output | 64 | Register write mask for the trap |

## Verification
Every request changes the sticky register and the trap outputs at the first rising edge after it is presented. Nothing appears combinationally, and nothing persists past the next edge. The bench drives each request on a falling edge and samples all four outputs on the following falling edge, after exactly one rising edge. It compares them against a model updated once per step. Idle steps placed directly after traps confirm that the strobe, summary and mask drop after one cycle and that the sticky value holds.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
    localparam int NFLAG  = 6;
    localparam int SUM_W  = NFLAG + 1;
    localparam int F_INV  = 0;
    localparam int F_DZE  = 1;
    localparam int F_OVF  = 2;
    localparam int F_UNF  = 3;
    localparam int F_INE  = 4;
    localparam int F_IOV  = 5;
    localparam int S_SWC  = NFLAG;

    typedef logic [NFLAG-1:0] flags_t;
    typedef logic [SUM_W-1:0] sum_t;
endpackage

// File: rtl/fpt_flag_eval.sv
module fpt_flag_eval
    import fpt_pkg::*;
(
    input  flags_t flags,
    input  flags_t ign_mask,
    input  flags_t en_mask,
    input  logic   swc_mode,
    output flags_t set_bits,
    output logic   fire,
    output sum_t   sum
);
    flags_t kept;

    always_comb begin
        kept = flags & ~ign_mask;
        fire = |kept;
        if (swc_mode) begin
            set_bits = kept;
            sum      = {1'b1, kept & en_mask};
        end else begin
            set_bits = flags;
            sum      = {1'b0, kept};
        end
        if (!fire) sum = '0;
    end
endmodule

// File: rtl/fpt_opnd_screen.sv
module fpt_opnd_screen
    import fpt_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int MAG_W = EXP_W + FRAC_W
) (
    input  logic [MAG_W-1:0] mag,
    input  logic             cmp,
    input  logic             swc_mode,
    input  logic             ftz,
    output flags_t           set_bits,
    output logic             fire,
    output sum_t             sum
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic denorm, allones, nan;

    always_comb begin
        ex       = mag[FRAC_W +: EXP_W];
        fr       = mag[FRAC_W-1:0];
        denorm   = (ex == '0) && (fr != '0);
        allones  = &ex;
        nan      = allones && (fr != '0);
        set_bits = '0;
        fire     = 1'b0;
        sum      = '0;
        if (swc_mode) begin
            if (denorm && !ftz) begin
                fire       = 1'b1;
                sum[F_INV] = 1'b1;
                sum[S_SWC] = 1'b1;
            end
        end else if (denorm) begin
            fire       = 1'b1;
            sum[F_INV] = 1'b1;
        end else if (cmp ? nan : allones) begin
            fire            = 1'b1;
            sum[F_INV]      = 1'b1;
            set_bits[F_INV] = 1'b1;
        end
    end
endmodule

// File: rtl/fpt_onehot_dec.sv
module fpt_onehot_dec #(
    parameter int IDX_W = 6,
    localparam int N    = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             en,
    output logic [N-1:0]     onehot
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign onehot[g] = en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/fp_trap_ctrl.sv
module fp_trap_ctrl
    import fpt_pkg::*;
#(
    parameter int RIDX_W = 6,
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int NREG  = 1 << RIDX_W,
    localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_req,
    input  logic [NFLAG-1:0]  flags,
    input  logic [NFLAG-1:0]  ign_mask,
    input  logic [NFLAG-1:0]  en_mask,
    input  logic [RIDX_W-1:0] dst_idx,
    input  logic              swc_mode,
    input  logic              chk_req,
    input  logic              chk_cmp,
    input  logic [OP_W-1:0]   opnd,
    input  logic              ftz,
    input  logic              sticky_we,
    input  logic [NFLAG-1:0]  sticky_wdata,
    output logic [NFLAG-1:0]  sticky_q,
    output logic              trap,
    output logic [SUM_W-1:0]  trap_sum,
    output logic [NREG-1:0]   trap_wmask
);
    typedef struct packed {
        flags_t          sticky;
        logic            trap;
        sum_t            sum;
        logic [NREG-1:0] wmask;
    } state_t;

    state_t st_d, st_q;

    flags_t fl_set, ck_set;
    logic   fl_fire, ck_fire;
    sum_t   fl_sum, ck_sum;
    logic [NREG-1:0] dec_mask;

    fpt_flag_eval i_flag (
        .flags(flags), .ign_mask(ign_mask), .en_mask(en_mask),
        .swc_mode(swc_mode), .set_bits(fl_set), .fire(fl_fire), .sum(fl_sum)
    );

    fpt_opnd_screen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_scr (
        .mag(opnd[OP_W-2:0]), .cmp(chk_cmp), .swc_mode(swc_mode), .ftz(ftz),
        .set_bits(ck_set), .fire(ck_fire), .sum(ck_sum)
    );

    fpt_onehot_dec #(.IDX_W(RIDX_W)) i_dec (
        .idx(dst_idx), .en(fl_fire), .onehot(dec_mask)
    );

    always_comb begin
        st_d        = st_q;
        st_d.trap   = 1'b0;
        st_d.sum    = '0;
        st_d.wmask  = '0;
        if (chk_req) begin
            st_d.sticky = st_q.sticky | ck_set;
            st_d.trap   = ck_fire;
            st_d.sum    = ck_sum;
        end else if (flag_req) begin
            st_d.sticky = st_q.sticky | fl_set;
            st_d.trap   = fl_fire;
            st_d.sum    = fl_sum;
            st_d.wmask  = dec_mask;
        end
        if (sticky_we) st_d.sticky = sticky_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_q   = st_q.sticky;
    assign trap       = st_q.trap;
    assign trap_sum   = st_q.sum;
    assign trap_wmask = st_q.wmask;

    // R4
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |-> (trap_sum == '0 && trap_wmask == '0));

    // R4
    flag_wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_req && !chk_req) && trap) |->
            (trap_wmask == (NREG'(1) << $past(dst_idx))));

    // R10
    chk_wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_req) |-> (trap_wmask == '0));

    // R5
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(flag_req || chk_req));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!flag_req && !chk_req && !sticky_we) |-> $stable(sticky_q));

    // R2
    sticky_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sticky_we) |-> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R3
    swc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_sum[S_SWC] |-> trap);
endmodule

// File: tb/test_fp_trap_ctrl.sv
module test_fp_trap_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flag_req, swc_mode, chk_req, chk_cmp, ftz, sticky_we;
    logic [5:0]  flags, ign_mask, en_mask, dst_idx, sticky_wdata;
    logic [63:0] opnd;
    logic [5:0]  sticky_q;
    logic        trap;
    logic [6:0]  trap_sum;
    logic [63:0] trap_wmask;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [5:0] m_st;

    always #(CLK_P/2) clk = ~clk;

    fp_trap_ctrl i_fp_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .flag_req(flag_req), .flags(flags),
        .ign_mask(ign_mask), .en_mask(en_mask), .dst_idx(dst_idx),
        .swc_mode(swc_mode), .chk_req(chk_req), .chk_cmp(chk_cmp),
        .opnd(opnd), .ftz(ftz), .sticky_we(sticky_we),
        .sticky_wdata(sticky_wdata), .sticky_q(sticky_q), .trap(trap),
        .trap_sum(trap_sum), .trap_wmask(trap_wmask)
    );

    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] P_DEN  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] N_DEN  = 64'h800F_FFFF_FFFF_FFFF;
    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;

    task automatic compare(input string tag, input logic [5:0] es, input logic et,
                           input logic [6:0] esum, input logic [63:0] ew);
        checks++;
        if (sticky_q !== es || trap !== et || trap_sum !== esum || trap_wmask !== ew) begin
            fails++;
            $display("FAIL %s: got st=%h trap=%b sum=%h wm=%h exp st=%h trap=%b sum=%h wm=%h",
                     tag, sticky_q, trap, trap_sum, trap_wmask, es, et, esum, ew);
        end
    endtask

    task automatic step(input string tag, input logic er, input logic cr, input logic cmp,
                        input logic swc, input logic fz, input logic we,
                        input logic [5:0] fl, input logic [5:0] ign, input logic [5:0] en,
                        input logic [5:0] wd, input logic [5:0] dst, input logic [63:0] op);
        logic [5:0]  nst, s;
        logic        et;
        logic [6:0]  esum;
        logic [63:0] ew;
        logic [10:0] ex;
        logic        den, allone, nan;
        flag_req = er; chk_req = cr; chk_cmp = cmp; swc_mode = swc; ftz = fz;
        sticky_we = we; flags = fl; ign_mask = ign; en_mask = en;
        sticky_wdata = wd; dst_idx = dst; opnd = op;
        nst = m_st; et = 0; esum = '0; ew = '0;
        ex = op[62:52];
        den = (ex == 0) && (op[51:0] != 0);
        allone = &ex;
        nan = allone && (op[51:0] != 0);
        if (cr) begin
            if (swc) begin
                if (den && !fz) begin et = 1; esum = 7'h41; end
            end else if (den) begin
                et = 1; esum = 7'h01;
            end else if (cmp ? nan : allone) begin
                et = 1; esum = 7'h01; nst[0] = 1'b1;
            end
        end else if (er) begin
            s = fl & ~ign;
            if (swc) begin
                nst = nst | s;
                if (s != 0) begin et = 1; esum = {1'b1, s & en}; ew = 64'd1 << dst; end
            end else begin
                nst = nst | fl;
                if (s != 0) begin et = 1; esum = {1'b0, s}; ew = 64'd1 << dst; end
            end
        end
        if (we) nst = wd;
        @(posedge clk);
        @(negedge clk);
        compare(tag, nst, et, esum, ew);
        m_st = nst;
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 6'h3F, 6'h00, 6'h3F, 6'h00, 6'd7, QNAN);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] op;
        void'($urandom(32'd1337));
        m_st = '0;
        rst_n = 0;
        flag_req = 0; chk_req = 0; chk_cmp = 0; swc_mode = 0; ftz = 0;
        sticky_we = 0; flags = 0; ign_mask = 0; en_mask = 0;
        sticky_wdata = 0; dst_idx = 0; opnd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1 reset", 6'h00, 0, 7'h00, 64'h0);

        // R2: all flags recorded, ignored ones do not trap, enable irrelevant
        step("R2 ignore-after-record", 1,0,0,0,0,0, 6'h11, 6'h10, 6'h00, 0, 6'd3, ONE);
        idle("R5 strobe drops");
        step("R2 fully ignored no trap", 1,0,0,0,0,0, 6'h06, 6'h06, 6'h3F, 0, 6'd9, ONE);
        step("R6 empty flags", 1,0,0,1,0,0, 6'h00, 6'h00, 6'h3F, 0, 6'd9, ONE);
        // R11: explicit write clears
        step("R11 sticky write", 0,0,0,0,0,1, 6'h00, 0, 0, 6'h00, 6'd0, ONE);
        // R3: ignored never recorded, summary filtered by enable
        step("R3 swc filter", 1,0,0,1,0,0, 6'h23, 6'h02, 6'h20, 0, 6'd63, ONE);
        idle("R5 strobe drops after swc");
        step("R3 swc no enable", 1,0,0,1,0,0, 6'h08, 6'h00, 6'h00, 0, 6'd0, ONE);
        step("R3 swc all ignored", 1,0,0,1,0,0, 6'h10, 6'h10, 6'h3F, 0, 6'd5, ONE);
        step("R11 write beats accumulate", 1,0,0,0,0,1, 6'h3F, 0, 0, 6'h02, 6'd1, ONE);
        // R7 / R8 / R9 / R10
        step("R7 arith denormal", 0,1,0,0,0,0, 0,0,0,0, 6'd4, P_DEN);
        step("R7 arith infinity", 0,1,0,0,0,0, 0,0,0,0, 6'd4, N_INF);
        step("R11 write clear", 0,0,0,0,0,1, 0,0,0,6'h00, 6'd0, ONE);
        step("R8 cmp infinity passes", 0,1,1,0,0,0, 0,0,0,0, 6'd4, P_INF);
        step("R8 cmp nan", 0,1,1,0,0,0, 0,0,0,0, 6'd4, QNAN);
        step("R8 cmp denormal", 0,1,1,0,0,0, 0,0,0,0, 6'd4, N_DEN);
        step("R9 swc denormal", 0,1,0,1,0,0, 0,0,0,0, 6'd4, N_DEN);
        step("R9 swc denormal ftz", 0,1,0,1,1,0, 0,0,0,0, 6'd4, P_DEN);
        step("R9 swc nan passes", 0,1,0,1,0,0, 0,0,0,0, 6'd4, QNAN);
        step("R9 swc zero passes", 0,1,0,1,0,0, 0,0,0,0, 6'd4, P_ZERO);
        step("R10 R11 check over flags", 1,1,0,0,0,0, 6'h3F, 0, 6'h3F, 0, 6'd8, ONE);

        for (int i = 0; i < 400; i++) begin
            logic er, cr, we;
            int k;
            k = $urandom_range(0, 9);
            er = (k < 5); cr = (k >= 5 && k < 8); we = (k == 8);
            if ($urandom_range(0, 7) == 0) cr = 1;
            case ($urandom_range(0, 5))
                0: op = P_ZERO;
                1: op = {1'b0, 11'h0, 52'($urandom) | 52'd1};
                2: op = {1'b1, 11'h0, 20'($urandom), 32'($urandom)};
                3: op = $urandom_range(0, 1) ? P_INF : N_INF;
                4: op = {1'($urandom), 11'h7FF, 20'($urandom) | 20'd1, 32'($urandom)};
                default: op = {1'($urandom), 11'($urandom_range(1, 2046)), 20'($urandom), 32'($urandom)};
            endcase
            step(cr ? "R7 R8 R9 random check" : (er ? "R2 R3 R4 random flags" : "R6 R11 random idle"),
                 er, cr, 1'($urandom), 1'($urandom), 1'($urandom), we,
                 6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom), op);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule